// File: doc/BRIEF.md
# Page Write Buffer Sequencer

This block is the back end of a paged flash: it collects the data bytes of a page-modifying command in a one-page buffer and then carries out the internal cycle against a synchronous memory array. The front end marks where a command starts, supplies its opcode and target address, streams its data bytes, and signals acceptance. Acceptance stands in for chip select going high on a byte boundary. From then on the sequencer owns the array port and holds `busy` high until the cycle is over.

A page write is a full read-merge-erase-program sequence. The whole addressed page is read first, and every buffer slot the host did not load takes the stored byte. The page is then driven to all ones and programmed from the buffer, so any bit can end up 0 or 1. A page program reads and merges the same way, but loaded slots become the stored byte ANDed with the new byte, and the page is not erased. Page erase and sector erase only drive ones. A sector is either half of the array. A write-protect input, active low, blocks every modifying cycle aimed at the lower half of the array. With the default 17-bit address that lower half is the first 256 pages.

Top module: `page_write_seq`

## Requirements
- R1: After a start request, data bytes fill the buffer from the offset in address bits [7:0]. The index wraps from 255 to 0 inside the same page, and a later byte replaces an earlier one in the same slot.
- R2: Page write (opcode 2'd0): every byte of the addressed page ends equal to the last byte loaded for its offset, or keeps its old value if none was loaded. No other byte of the array changes.
- R3: Page program (opcode 2'd1): a loaded offset ends as old AND new, and an unloaded offset keeps its old value.
- R4: Page erase (opcode 2'd2) sets all bytes of the addressed page to 8'hFF.
- R5: Sector erase (opcode 2'd3) sets to 8'hFF every byte whose address MSB equals the target's MSB, and nothing else.
- R6: While `wp_n` is 0 at acceptance, a command whose address MSB is 0 is dropped. `busy` stays low and the array is unchanged.
- R7: `busy` is high from the cycle after acceptance, for exactly 257+256+E+256+P cycles on a page write, 257+256+P on a page program, 256+E on a page erase and 2^(ADDR_W-1)+E on a sector erase (E = ERASE_CLKS, P = PROG_CLKS).
- R8: Start, data and accept pulses that arrive while `busy` is high have no effect. They neither lengthen the cycle nor start another one.
- R9: Right after reset, `busy`, `arr_rd` and `arr_we` are 0.
- R10: The array is read or written only while `busy` is high, and never read and written in the same cycle.
- R11: A page write or page program accepted with no data bytes loaded is dropped, and `busy` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_begin | input | 1 | Start of a command: captures opcode and address, clears the buffer mask |
| cmd_op | input | 2 | Opcode: 0 page write, 1 page program, 2 page erase, 3 sector erase |
| cmd_addr | input | ADDR_W | Target byte address |
| data_valid | input | 1 | A data byte is present on data_byte |
| data_byte | input | 8 | Data byte to load into the buffer |
| cmd_commit | input | 1 | Command accepted; the internal cycle may start |
| wp_n | input | 1 | Write protect for the lower array half, active low |
| busy | output | 1 | Internal cycle in progress |
| arr_addr | output | ADDR_W | Array byte address |
| arr_rd | output | 1 | Array read strobe; data is returned the next cycle |
| arr_we | output | 1 | Array write strobe |
| arr_wdata | output | 8 | Array write data |
| arr_rdata | input | 8 | Array read data, one cycle after arr_rd |

## Verification
Two things can share a cycle. One is a cycle still running; the other is a new command arriving from the front end, or the protect pin turning a fresh acceptance into a no-op. The bench starts a page erase and, while `busy` is high, sends a full page-write command with data bytes and an accept pulse. The result is judged on three points: the erase length stays at its own formula, `busy` does not rise again afterwards, and the whole array matches a model to which only the erase was applied. A second group of cases sweeps start offsets and byte counts, including wrap-around and overwrite, with the expected array computed byte by byte in the bench.

// File: rtl/pgseq_pkg.sv
package pgseq_pkg;

    typedef enum logic [1:0] {
        OP_PWRITE = 2'd0,
        OP_PPROG  = 2'd1,
        OP_PERASE = 2'd2,
        OP_SERASE = 2'd3
    } op_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_FETCH,
        ST_ERASE,
        ST_EDWELL,
        ST_PROG,
        ST_PDWELL
    } st_e;

    // Opcodes that carry data bytes into the page buffer
    function automatic logic fills_buffer(input op_e op);
        return (op == OP_PWRITE) || (op == OP_PPROG);
    endfunction

    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/pgseq_buf.sv
module pgseq_buf #(
    parameter int PAGE_AW = 8
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               clr,
    input  logic [PAGE_AW-1:0] start_idx,
    input  logic               ld_en,
    input  logic [7:0]         ld_byte,
    input  logic               mrg_en,
    input  logic [PAGE_AW-1:0] mrg_idx,
    input  logic [7:0]         mrg_old,
    input  logic               mrg_and,
    input  logic [PAGE_AW-1:0] rd_idx,
    output logic [7:0]         rd_byte,
    output logic               any_ld
);
    localparam int PAGE_N = 1 << PAGE_AW;

    logic [PAGE_AW-1:0] wi;
    logic [7:0]         slot_byte [PAGE_N];

    // Fill index wraps naturally inside the page width
    always_ff @(posedge clk) begin
        if (rst) begin
            wi     <= '0;
            any_ld <= 1'b0;
        end else if (clr) begin
            wi     <= start_idx;
            any_ld <= 1'b0;
        end else if (ld_en) begin
            wi     <= wi + PAGE_AW'(1);
            any_ld <= 1'b1;
        end
    end

    for (genvar g = 0; g < PAGE_N; g++) begin : g_slot
        logic       v_q;
        logic [7:0] b_q;
        logic       hit_ld;
        logic       hit_mrg;

        assign hit_ld  = ld_en && !clr && (wi == PAGE_AW'(g));
        assign hit_mrg = mrg_en && (mrg_idx == PAGE_AW'(g));

        always_ff @(posedge clk) begin
            if (rst || clr) begin
                v_q <= 1'b0;
            end else if (hit_ld) begin
                v_q <= 1'b1;
            end
        end

        always_ff @(posedge clk) begin
            if (hit_ld) begin
                b_q <= ld_byte;
            end else if (hit_mrg) begin
                if (!v_q) begin
                    b_q <= mrg_old;
                end else if (mrg_and) begin
                    b_q <= b_q & mrg_old;
                end
            end
        end

        assign slot_byte[g] = b_q;
    end

    assign rd_byte = slot_byte[rd_idx];

endmodule

// File: rtl/pgseq_guard.sv
module pgseq_guard
    import pgseq_pkg::*;
(
    input  logic commit,
    input  logic busy,
    input  logic sess_open,
    input  op_e  sess_op,
    input  logic tgt_msb,
    input  logic wp_n,
    input  logic any_ld,
    output logic go,
    output logic close
);
    logic locked;
    logic has_payload;

    always_comb begin
        locked      = !wp_n && !tgt_msb;
        has_payload = !fills_buffer(sess_op) || any_ld;
        close       = commit && !busy;
        go          = close && sess_open && has_payload && !locked;
    end

endmodule

// File: rtl/pgseq_ctrl.sv
module pgseq_ctrl
    import pgseq_pkg::*;
#(
    parameter int ADDR_W     = 17,
    parameter int PAGE_AW    = 8,
    parameter int ERASE_CLKS = 16,
    parameter int PROG_CLKS  = 8
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      go,
    input  op_e                       go_op,
    input  logic [ADDR_W-PAGE_AW-1:0] go_page,
    output logic                      busy,
    output logic [ADDR_W-1:0]         arr_addr,
    output logic                      arr_rd,
    output logic                      arr_we,
    output logic                      prog_phase,
    output logic [PAGE_AW-1:0]        slot,
    output logic                      mrg_en,
    output logic [PAGE_AW-1:0]        mrg_idx,
    output logic                      mrg_and
);
    localparam int PAGE_N = 1 << PAGE_AW;
    localparam int SECT_N = 1 << (ADDR_W - 1);
    localparam int CW = imax(imax(ADDR_W, PAGE_AW + 2),
                             imax($clog2(ERASE_CLKS + 1), $clog2(PROG_CLKS + 1)));
    localparam logic [CW-1:0] FETCH_LAST = CW'(PAGE_N);
    localparam logic [CW-1:0] PAGE_LAST  = CW'(PAGE_N - 1);
    localparam logic [CW-1:0] SECT_LAST  = CW'(SECT_N - 1);
    localparam logic [CW-1:0] E_LAST     = CW'(ERASE_CLKS - 1);
    localparam logic [CW-1:0] P_LAST     = CW'(PROG_CLKS - 1);

    st_e                       st;
    op_e                       op_q;
    logic [ADDR_W-PAGE_AW-1:0] page_q;
    logic [CW-1:0]             cnt;
    logic                      rd_q;
    logic [PAGE_AW-1:0]        rd_idx_q;
    logic [CW-1:0]             erase_last;

    assign erase_last = (op_q == OP_SERASE) ? SECT_LAST : PAGE_LAST;

    always_ff @(posedge clk) begin
        if (rst) begin
            st       <= ST_IDLE;
            op_q     <= OP_PWRITE;
            page_q   <= '0;
            cnt      <= '0;
            rd_q     <= 1'b0;
            rd_idx_q <= '0;
        end else begin
            rd_q     <= arr_rd;
            rd_idx_q <= cnt[PAGE_AW-1:0];
            unique case (st)
                ST_IDLE: begin
                    if (go) begin
                        op_q   <= go_op;
                        page_q <= go_page;
                        cnt    <= '0;
                        st     <= fills_buffer(go_op) ? ST_FETCH : ST_ERASE;
                    end
                end
                ST_FETCH: begin
                    if (cnt == FETCH_LAST) begin
                        cnt <= '0;
                        st  <= (op_q == OP_PWRITE) ? ST_ERASE : ST_PROG;
                    end else begin
                        cnt <= cnt + CW'(1);
                    end
                end
                ST_ERASE: begin
                    if (cnt == erase_last) begin
                        cnt <= '0;
                        st  <= ST_EDWELL;
                    end else begin
                        cnt <= cnt + CW'(1);
                    end
                end
                ST_EDWELL: begin
                    if (cnt == E_LAST) begin
                        cnt <= '0;
                        st  <= fills_buffer(op_q) ? ST_PROG : ST_IDLE;
                    end else begin
                        cnt <= cnt + CW'(1);
                    end
                end
                ST_PROG: begin
                    if (cnt == PAGE_LAST) begin
                        cnt <= '0;
                        st  <= ST_PDWELL;
                    end else begin
                        cnt <= cnt + CW'(1);
                    end
                end
                ST_PDWELL: begin
                    if (cnt == P_LAST) begin
                        cnt <= '0;
                        st  <= ST_IDLE;
                    end else begin
                        cnt <= cnt + CW'(1);
                    end
                end
                default: st <= ST_IDLE;
            endcase
        end
    end

    logic [ADDR_W-1:0] page_addr;
    logic [ADDR_W-1:0] sect_addr;

    always_comb begin
        page_addr  = {page_q, cnt[PAGE_AW-1:0]};
        sect_addr  = {page_q[ADDR_W-PAGE_AW-1], cnt[ADDR_W-2:0]};
        busy       = (st != ST_IDLE);
        arr_rd     = (st == ST_FETCH) && (cnt < FETCH_LAST);
        arr_we     = (st == ST_ERASE) || (st == ST_PROG);
        prog_phase = (st == ST_PROG);
        slot       = cnt[PAGE_AW-1:0];
        arr_addr   = ((st == ST_ERASE) && (op_q == OP_SERASE)) ? sect_addr : page_addr;
        mrg_en     = rd_q;
        mrg_idx    = rd_idx_q;
        mrg_and    = (op_q == OP_PPROG);
    end

endmodule

// File: rtl/page_write_seq.sv
module page_write_seq
    import pgseq_pkg::*;
#(
    parameter int ADDR_W     = 17,
    parameter int PAGE_AW    = 8,
    parameter int ERASE_CLKS = 16,
    parameter int PROG_CLKS  = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cmd_begin,
    input  logic [1:0]        cmd_op,
    input  logic [ADDR_W-1:0] cmd_addr,
    input  logic              data_valid,
    input  logic [7:0]        data_byte,
    input  logic              cmd_commit,
    input  logic              wp_n,
    output logic              busy,
    output logic [ADDR_W-1:0] arr_addr,
    output logic              arr_rd,
    output logic              arr_we,
    output logic [7:0]        arr_wdata,
    input  logic [7:0]        arr_rdata
);
    localparam int PG_W = ADDR_W - PAGE_AW;

    logic            sess_open;
    op_e             sess_op;
    logic [PG_W-1:0] sess_page;
    logic            take_begin;
    logic            go;
    logic            close;
    logic            any_ld;
    logic            ld_en;
    logic            prog_phase;
    logic [PAGE_AW-1:0] slot;
    logic            mrg_en;
    logic [PAGE_AW-1:0] mrg_idx;
    logic            mrg_and;
    logic [7:0]      buf_byte;

    assign take_begin = cmd_begin && !busy;
    assign ld_en      = data_valid && !busy && sess_open && fills_buffer(sess_op);

    always_ff @(posedge clk) begin
        if (rst) begin
            sess_open <= 1'b0;
            sess_op   <= OP_PWRITE;
            sess_page <= '0;
        end else if (take_begin) begin
            sess_open <= 1'b1;
            sess_op   <= op_e'(cmd_op);
            sess_page <= cmd_addr[ADDR_W-1:PAGE_AW];
        end else if (close) begin
            sess_open <= 1'b0;
        end
    end

    pgseq_buf #(.PAGE_AW(PAGE_AW)) u_buf (
        .clk       (clk),
        .rst       (rst),
        .clr       (take_begin),
        .start_idx (cmd_addr[PAGE_AW-1:0]),
        .ld_en     (ld_en),
        .ld_byte   (data_byte),
        .mrg_en    (mrg_en),
        .mrg_idx   (mrg_idx),
        .mrg_old   (arr_rdata),
        .mrg_and   (mrg_and),
        .rd_idx    (slot),
        .rd_byte   (buf_byte),
        .any_ld    (any_ld)
    );

    pgseq_guard u_guard (
        .commit    (cmd_commit),
        .busy      (busy),
        .sess_open (sess_open),
        .sess_op   (sess_op),
        .tgt_msb   (sess_page[PG_W-1]),
        .wp_n      (wp_n),
        .any_ld    (any_ld),
        .go        (go),
        .close     (close)
    );

    pgseq_ctrl #(
        .ADDR_W     (ADDR_W),
        .PAGE_AW    (PAGE_AW),
        .ERASE_CLKS (ERASE_CLKS),
        .PROG_CLKS  (PROG_CLKS)
    ) u_ctrl (
        .clk        (clk),
        .rst        (rst),
        .go         (go),
        .go_op      (sess_op),
        .go_page    (sess_page),
        .busy       (busy),
        .arr_addr   (arr_addr),
        .arr_rd     (arr_rd),
        .arr_we     (arr_we),
        .prog_phase (prog_phase),
        .slot       (slot),
        .mrg_en     (mrg_en),
        .mrg_idx    (mrg_idx),
        .mrg_and    (mrg_and)
    );

    assign arr_wdata = prog_phase ? buf_byte : 8'hFF;

endmodule

// File: rtl/page_write_seq_chk.sv
module page_write_seq_chk #(
    parameter int ADDR_W  = 17,
    parameter int PAGE_AW = 8
) (
    input logic                      clk,
    input logic                      rst,
    input logic                      busy,
    input logic                      arr_rd,
    input logic                      arr_we,
    input logic                      cmd_commit,
    input logic                      wp_n,
    input logic [ADDR_W-PAGE_AW-1:0] sess_page
);
    p_rdwe_excl_r10: assert property (@(posedge clk) disable iff (rst)
        !(arr_rd && arr_we));

    p_access_busy_r10: assert property (@(posedge clk) disable iff (rst)
        (arr_rd || arr_we) |-> busy);

    p_start_commit_r7: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> $past(cmd_commit));

    p_locked_stays_idle_r6: assert property (@(posedge clk) disable iff (rst)
        (cmd_commit && !busy && !wp_n && !sess_page[ADDR_W-PAGE_AW-1]) |=> !busy);

    p_reset_idle_r9: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!busy && !arr_we && !arr_rd));

endmodule

bind page_write_seq page_write_seq_chk #(.ADDR_W(ADDR_W), .PAGE_AW(PAGE_AW)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .busy       (busy),
    .arr_rd     (arr_rd),
    .arr_we     (arr_we),
    .cmd_commit (cmd_commit),
    .wp_n       (wp_n),
    .sess_page  (sess_page)
);

// File: tb/tb_page_write_seq.sv
module tb_page_write_seq;
    localparam int AW    = 11;
    localparam int EC    = 5;
    localparam int PC    = 3;
    localparam int MEM_N = 1 << AW;
    localparam int SECT  = 1 << (AW - 1);

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          cmd_begin = 1'b0;
    logic [1:0]    cmd_op = 2'd0;
    logic [AW-1:0] cmd_addr = '0;
    logic          data_valid = 1'b0;
    logic [7:0]    data_byte = 8'd0;
    logic          cmd_commit = 1'b0;
    logic          wp_n = 1'b1;
    logic          busy;
    logic [AW-1:0] arr_addr;
    logic          arr_rd;
    logic          arr_we;
    logic [7:0]    arr_wdata;
    logic [7:0]    arr_rdata;

    int total = 0;
    int bad = 0;
    int port_viol = 0;
    bit finished = 0;

    logic [7:0] mem   [MEM_N];
    logic [7:0] ref_m [MEM_N];

    always #5 clk = ~clk;

    page_write_seq #(.ADDR_W(AW), .PAGE_AW(8), .ERASE_CLKS(EC), .PROG_CLKS(PC)) dut (
        .clk(clk), .rst(rst), .cmd_begin(cmd_begin), .cmd_op(cmd_op), .cmd_addr(cmd_addr),
        .data_valid(data_valid), .data_byte(data_byte), .cmd_commit(cmd_commit), .wp_n(wp_n),
        .busy(busy), .arr_addr(arr_addr), .arr_rd(arr_rd), .arr_we(arr_we),
        .arr_wdata(arr_wdata), .arr_rdata(arr_rdata)
    );

    // Synchronous array model, read data one cycle after the strobe
    always @(posedge clk) begin
        if (arr_rd) arr_rdata <= mem[arr_addr];
        if (arr_we) mem[arr_addr] <= arr_wdata;
    end

    always @(negedge clk) begin
        if (!rst && ((arr_rd && arr_we) || ((arr_rd || arr_we) && !busy))) port_viol++;
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic cmp_mem(input string req);
        int mism = 0;
        int first = -1;
        for (int i = 0; i < MEM_N; i++) begin
            if (mem[i] !== ref_m[i]) begin
                mism++;
                if (first < 0) first = i;
            end
        end
        chk(mism == 0, req, mism, 0);
        if (mism != 0) $display("  first mismatch addr=%0d got=%0h want=%0h", first, mem[first], ref_m[first]);
    endtask

    function automatic int exp_cycles(input int op);
        case (op)
            0: return 257 + 256 + EC + 256 + PC;
            1: return 257 + 256 + PC;
            2: return 256 + EC;
            default: return SECT + EC;
        endcase
    endfunction

    task automatic drive_begin(input int op, input int addr);
        cmd_begin = 1'b1;
        cmd_op    = 2'(op);
        cmd_addr  = AW'(addr);
        @(negedge clk);
        cmd_begin = 1'b0;
    endtask

    task automatic drive_bytes(input int n, input int seed);
        for (int k = 0; k < n; k++) begin
            data_valid = 1'b1;
            data_byte  = 8'(seed + k * 29);
            @(negedge clk);
        end
        data_valid = 1'b0;
    endtask

    task automatic drive_commit();
        cmd_commit = 1'b1;
        @(negedge clk);
        cmd_commit = 1'b0;
    endtask

    task automatic wait_idle(output int cyc);
        cyc = 0;
        while (busy) begin
            cyc++;
            @(negedge clk);
        end
    endtask

    task automatic do_cmd(input int op, input int addr, input int n, input int seed,
                          input logic wp, input string req);
        logic [7:0] fin [256];
        bit had [256];
        int off, base, cyc, sec;
        bit prot, accept;
        off  = addr & 255;
        base = addr & ~255;
        for (int i = 0; i < 256; i++) begin fin[i] = 8'd0; had[i] = 0; end
        for (int k = 0; k < n; k++) begin
            fin[(off + k) % 256] = 8'(seed + k * 29);
            had[(off + k) % 256] = 1;
        end
        prot   = !wp && (((addr >> (AW - 1)) & 1) == 0);
        accept = !prot && (op >= 2 || n > 0);
        wp_n = wp;
        drive_begin(op, addr);
        drive_bytes(n, seed);
        drive_commit();
        wait_idle(cyc);
        if (accept) begin
            case (op)
                0: for (int i = 0; i < 256; i++) if (had[i]) ref_m[base + i] = fin[i];
                1: for (int i = 0; i < 256; i++) if (had[i]) ref_m[base + i] = ref_m[base + i] & fin[i];
                2: for (int i = 0; i < 256; i++) ref_m[base + i] = 8'hFF;
                default: begin
                    sec = (addr >> (AW - 1)) & 1;
                    for (int i = 0; i < SECT; i++) ref_m[sec * SECT + i] = 8'hFF;
                end
            endcase
        end
        chk(cyc == (accept ? exp_cycles(op) : 0), {req, " R7 busy length"}, cyc,
            accept ? exp_cycles(op) : 0);
        cmp_mem({req, " array contents"});
        wp_n = 1'b1;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=running expected=done");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        int cyc;
        for (int i = 0; i < MEM_N; i++) begin
            mem[i]   = 8'(i * 37 + 5);
            ref_m[i] = 8'(i * 37 + 5);
        end
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R9 reset state
        chk(busy == 1'b0, "R9 busy after reset", busy, 0);
        chk(arr_we == 1'b0 && arr_rd == 1'b0, "R9 array strobes after reset", {arr_rd, arr_we}, 0);

        // R2 page write: full page, single byte
        do_cmd(0, 'h100, 256, 11, 1'b1, "R2 full page write");
        do_cmd(0, 'h20A, 1, 77, 1'b1, "R2 single byte write");
        // R1 wrap and overwrite
        do_cmd(0, 'h5FA, 12, 3, 1'b1, "R1 wrap at page end");
        do_cmd(0, 'h603, 300, 91, 1'b1, "R1 overwrite after wrap");
        // R2 sweep of offsets and counts
        for (int o = 0; o < 4; o++) begin
            for (int n = 1; n <= 5; n += 4) begin
                do_cmd(0, 'h700 + (o == 3 ? 255 : o * 64), n, o * 17 + n, 1'b1, "R2 offset sweep");
            end
        end
        // R3 page program
        do_cmd(1, 'h500, 40, 200, 1'b1, "R3 program AND");
        do_cmd(1, 'h6F0, 20, 5, 1'b1, "R3 program with wrap");
        // R4 page erase
        do_cmd(2, 'h300, 0, 0, 1'b1, "R4 page erase");
        // R5 sector erase upper half allowed while protected
        do_cmd(3, 'h480, 0, 0, 1'b0, "R5 upper sector erase");
        // R6 protected lower half
        do_cmd(0, 'h010, 8, 9, 1'b0, "R6 locked page write");
        do_cmd(1, 'h200, 8, 9, 1'b0, "R6 locked page program");
        do_cmd(2, 'h100, 0, 0, 1'b0, "R6 locked page erase");
        do_cmd(3, 'h000, 0, 0, 1'b0, "R6 locked sector erase");
        // R6 upper half still writable while protected
        do_cmd(0, 'h612, 6, 44, 1'b0, "R6 upper page write");
        // R11 empty data phase
        do_cmd(0, 'h520, 0, 0, 1'b1, "R11 empty page write");
        do_cmd(1, 'h520, 0, 0, 1'b1, "R11 empty page program");
        // R8 commands during a running page erase
        drive_begin(2, 'h400);
        drive_commit();
        chk(busy == 1'b1, "R7 busy one cycle after accept", busy, 1);
        drive_begin(0, 'h600);
        drive_bytes(3, 50);
        drive_commit();
        wait_idle(cyc);
        for (int i = 0; i < 256; i++) ref_m['h400 + i] = 8'hFF;
        chk(cyc + 5 == exp_cycles(2), "R8 erase length unchanged", cyc + 5, exp_cycles(2));
        cyc = 0;
        for (int k = 0; k < 8; k++) begin
            if (busy) cyc++;
            @(negedge clk);
        end
        chk(cyc == 0, "R8 no second cycle", cyc, 0);
        cmp_mem("R8 array after ignored command");
        // R5 lower sector erase when unprotected
        do_cmd(3, 'h2C0, 0, 0, 1'b1, "R5 lower sector erase");
        // R10 port discipline throughout
        chk(port_viol == 0, "R10 array access outside busy or overlap", port_viol, 0);

        finished = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule